// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block is the bus master for the two-wire PHY management interface. Software programs it through four 32-bit words at word offsets 12 to 15 of a small register window. It generates the management clock from the system clock and shifts complete frames out on the data line. In the direct mode, used by 1G PHYs, a frame carries a 5-bit register number. In the indirect mode, used by 10G PHYs, an address frame is sent first and a data frame follows it.

Each frame is started as a side effect of a register write. Writing the data word sends a write frame. Writing the address word in indirect mode sends an address frame. Writing the control word with its read bit set sends a read frame. While a frame is on the wire, a busy flag stays set and every further register write is dropped. At the end of a read, the 16 captured bits stay in the data word until the next frame or data write. A missing turnaround response from the PHY is flagged as a read error.

Top module: `mdio_regmaster`

## Requirements
- R1: After reset, busy, read error, indirect mode and preamble suppression read 0. The divider reads the `DIV_RST` parameter. The control, data and address words read 0. `mdc` is low and `mdio_oe` is low.
- R2: Word 12 reads busy at bit 0 and read error at bit 1. It reads and writes preamble suppression at bit 5, indirect mode at bit 6 and the divider at bits 15:7. Writes to bits 0 and 1 have no effect. Word 13 holds the device or register number at bits 4:0 and the PHY address at bits 9:5; its bit 15 always reads 0. Words 14 and 15 hold 16-bit data and address values in bits 15:0. Every other word reads 0.
- R3: A data-word write sends a write frame MSB first. The frame is: start 01 (direct) or 00 (indirect), opcode 01, PHY address, device number, turnaround 10, then the 16 written bits. `mdio_oe` stays high for the whole frame, and `mdio_o` changes only while `mdc` falls.
- R4: In indirect mode, an address-word write sends an address frame: start 00, opcode 00, turnaround 10, then the written value. In direct mode, the same write only stores the value, and no `mdc` edge occurs.
- R5: A control-word write with bit 15 set sends a read frame using the newly written addresses. The opcode is 10 in direct mode and 11 in indirect mode. `mdio_oe` drops for the two turnaround bits and the 16 data bits. The 16 bits sampled on the rising edges of `mdc` then appear in the data word, MSB first.
- R6: If `mdio_i` is high at the rising edge of the second turnaround bit of a read, the read error bit is set. A read whose turnaround is driven low clears the bit.
- R7: Each `mdc` half period lasts divider+1 clock cycles, starting low at the write. Busy stays high for 2·(divider+1)·N cycles, where N is 64 bits with the preamble and 32 without. `mdc` stays low while idle.
- R8: With preamble suppression clear, 32 ones precede the start bits. With it set, the frame begins directly with the start bits.
- R9: A divider value written below 5 is stored as 5.
- R10: While busy, writes to any word are ignored. No second frame follows, and the stored configuration, addresses and data are kept.
- R11: Read data stays unchanged in the data word while the bus is idle, for at least 16 `mdc` periods after busy clears.
- R12: A control-word write with bit 15 clear stores the addresses and starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word index for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the word at `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the external tri-state driver |
| mdio_i | input | 1 | Serial data in from the pad |

## Verification
The bench builds the block with `DIV_RST` set to 20, so the reset value of the divider is distinct from the values written later. Most frames run at the minimum legal divider of 5, which keeps a 64-bit frame under 800 cycles. This lets every mode mix run in a short simulation: direct and indirect encoding, with and without the preamble, and read, write and address frames. One frame runs with a divider of 9, to confirm that frame length scales with the divider. A behavioural PHY drives the turnaround and the read data, so both a clean read and a read error can be produced.

// File: rtl/mdio_regmaster.sv
module mdio_regmaster #(
  parameter int ADDR_W = 4,
  parameter logic [8:0] DIV_RST = 9'd63,
  parameter logic [8:0] DIV_MIN = 9'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] W_CFG = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] W_CTL = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] W_DAT = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] W_ADR = ADDR_W'(15);
  localparam logic [5:0] TA_BIT  = 6'd46;
  localparam logic [5:0] TA_LAST = 6'd47;
  localparam logic [5:0] LAST    = 6'd63;

  logic        busy, rd_frame, rd_err, pre_dis, c45, mdc_q;
  logic [8:0]  div_q, cnt;
  logic [5:0]  idx;
  logic [63:0] sh;
  logic [15:0] rx, data_q, addr_q;
  logic [4:0]  prt_q, dev_q;
  logic [31:0] frame;
  logic [1:0]  op;
  logic [8:0]  div_new;

  wire wr_ok  = reg_wr && !busy;
  wire wr_cfg = wr_ok && reg_addr == W_CFG;
  wire wr_ctl = wr_ok && reg_addr == W_CTL;
  wire wr_dat = wr_ok && reg_addr == W_DAT;
  wire wr_adr = wr_ok && reg_addr == W_ADR;
  wire go_rd  = wr_ctl && reg_wdata[15];
  wire go_adr = wr_adr && c45;
  wire go     = wr_dat || go_rd || go_adr;
  wire tick   = busy && cnt == div_q;
  wire rise   = tick && !mdc_q;
  wire fall   = tick && mdc_q;

  logic unused_hi;
  assign unused_hi = ^reg_wdata[31:16];

  assign div_new = (reg_wdata[15:7] < DIV_MIN) ? DIV_MIN : reg_wdata[15:7];
  assign op = go_adr ? 2'b00 : wr_dat ? 2'b01 : (c45 ? 2'b11 : 2'b10);

  always_comb begin
    frame = {c45 ? 2'b00 : 2'b01, op,
             go_rd ? reg_wdata[9:5] : prt_q,
             go_rd ? reg_wdata[4:0] : dev_q,
             go_rd ? 2'b11 : 2'b10,
             go_rd ? 16'hFFFF : reg_wdata[15:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; rd_frame <= 1'b0; rd_err <= 1'b0;
      pre_dis <= 1'b0; c45 <= 1'b0; mdc_q <= 1'b0;
      div_q <= DIV_RST; cnt <= '0; idx <= '0; sh <= '0; rx <= '0;
      data_q <= '0; addr_q <= '0; prt_q <= '0; dev_q <= '0;
    end else begin
      if (wr_cfg) begin
        div_q <= div_new; c45 <= reg_wdata[6]; pre_dis <= reg_wdata[5];
      end
      if (wr_ctl) begin
        dev_q <= reg_wdata[4:0]; prt_q <= reg_wdata[9:5];
      end
      if (wr_adr) addr_q <= reg_wdata[15:0];
      if (wr_dat) data_q <= reg_wdata[15:0];
      if (go) begin
        busy <= 1'b1; rd_frame <= go_rd; cnt <= '0; mdc_q <= 1'b0;
        idx <= pre_dis ? 6'd32 : 6'd0;
        sh  <= pre_dis ? {frame, 32'h0} : {32'hFFFF_FFFF, frame};
        if (go_rd) rd_err <= 1'b0;
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 9'd1;
        if (tick) mdc_q <= ~mdc_q;
        if (rise && rd_frame) begin
          if (idx == TA_LAST && mdio_i) rd_err <= 1'b1;
          if (idx > TA_LAST) rx <= {rx[14:0], mdio_i};
        end
        if (fall) begin
          if (idx == LAST) begin
            busy <= 1'b0;
            if (rd_frame) data_q <= rx;
          end else begin
            idx <= idx + 6'd1;
            sh  <= {sh[62:0], 1'b1};
          end
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = sh[63];
  assign mdio_oe = busy && !(rd_frame && idx >= TA_BIT);

  always_comb begin
    case (reg_addr)
      W_CFG:   reg_rdata = {16'h0, div_q, c45, pre_dis, 3'b000, rd_err, busy};
      W_CTL:   reg_rdata = {22'h0, prt_q, dev_q};
      W_DAT:   reg_rdata = {16'h0, data_q};
      W_ADR:   reg_rdata = {16'h0, addr_q};
      default: reg_rdata = 32'h0;
    endcase
  end
endmodule

module mdio_regmaster_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rd_frame,
  input logic       rd_err,
  input logic       reg_wr,
  input logic       mdc,
  input logic       mdio_oe,
  input logic [4:0] prt_q,
  input logic [4:0] dev_q,
  input logic [8:0] div_q
);
  p_mdc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  p_start_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !mdc);
  p_div_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    div_q >= 9'd5);
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr |=> $stable({prt_q, dev_q}) && $stable(div_q));
  p_oe_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) && busy |-> rd_frame);
  p_err_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_err) |-> rd_frame && busy);
endmodule

bind mdio_regmaster mdio_regmaster_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_frame(rd_frame),
  .rd_err(rd_err), .reg_wr(reg_wr), .mdc(mdc), .mdio_oe(mdio_oe),
  .prt_q(prt_q), .dev_q(dev_q), .div_q(div_q)
);

// File: tb/sim_mdio_regmaster.sv
`timescale 1ns/1ps
module sim_mdio_regmaster;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, mdio_i = 1'b1;
  logic [3:0] reg_addr = 4'd12;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, errors = 0, ncap = 0, cycles = 0;
  logic [63:0] cap_o = '0, cap_oe = '0;
  logic cur_pre = 1'b0, cur_tabad = 1'b0;
  logic [15:0] cur_resp = '0;

  always #2.5 clk = ~clk;

  mdio_regmaster #(.ADDR_W(4), .DIV_RST(9'd20)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always @(posedge mdc) begin
    int j;
    cap_o  = {cap_o[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    ncap   = ncap + 1;
    j = ncap - (cur_pre ? 0 : 32);
    if (j == 15) mdio_i = cur_tabad;
    else if (j >= 16 && j <= 31) mdio_i = cur_resp[31-j];
    else mdio_i = 1'b1;
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act %0d cycles exp < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0; reg_addr = 4'd12; #1;
    while (reg_rdata[0] && cyc < 100000) begin
      cyc++; @(negedge clk); reg_addr = 4'd12; #1;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // c45[30] pre[29] kind[28:27] (0 addr,1 write,2 read) prt[26:22] dev[21:17] val[16:1] tabad[0]
  localparam logic [30:0] VEC [6] = '{
    {1'b0, 1'b0, 2'd1, 5'h03, 5'h04, 16'hA5C3, 1'b0},
    {1'b0, 1'b0, 2'd2, 5'h1F, 5'h00, 16'h1234, 1'b0},
    {1'b1, 1'b0, 2'd0, 5'h02, 5'h1E, 16'hBEEF, 1'b0},
    {1'b1, 1'b1, 2'd1, 5'h11, 5'h07, 16'h0F0F, 1'b0},
    {1'b1, 1'b1, 2'd2, 5'h00, 5'h1F, 16'h8001, 1'b0},
    {1'b0, 1'b1, 2'd2, 5'h0A, 5'h15, 16'hDEAD, 1'b1}
  };

  initial begin
    logic [31:0] v;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd12, v); chk(v == 32'h0000_0A00, "R1 status", v, 32'h0A00);
    rd(4'd13, v); chk(v == 0, "R1 ctl", v, 0);
    rd(4'd14, v); chk(v == 0, "R1 data", v, 0);
    rd(4'd15, v); chk(v == 0, "R1 addr", v, 0);
    chk(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 0);

    wr(4'd12, 32'hFFFF_0000 | (9 << 7) | 32'h63);
    rd(4'd12, v); chk(v == 32'h4E0, "R2 cfg readback", v, 32'h4E0);
    rd(4'd3, v); chk(v == 0, "R2 unused word", v, 0);
    ncap = 0;
    wr(4'd13, 32'h3FF);
    idle(40);
    rd(4'd13, v); chk(v == 32'h3FF, "R2 ctl readback", v, 32'h3FF);
    rd(4'd12, v); chk(v[0] == 1'b0 && ncap == 0, "R12 no frame from ctl", {v[0], 32'(ncap)}, 0);

    for (int e = 0; e < 6; e++) begin
      logic [30:0] t;
      logic c45, pre, bad;
      logic [1:0] kind, op;
      logic [4:0] prt, dev;
      logic [15:0] val;
      logic [31:0] fr;
      logic [63:0] exp, mask;
      int n;
      t = VEC[e];
      c45 = t[30]; pre = t[29]; kind = t[28:27]; prt = t[26:22]; dev = t[21:17];
      val = t[16:1]; bad = t[0];
      cur_pre = pre; cur_resp = val; cur_tabad = bad;
      wr(4'd12, (5 << 7) | (32'(c45) << 6) | (32'(pre) << 5));
      op = (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : (c45 ? 2'b11 : 2'b10);
      fr = {c45 ? 2'b00 : 2'b01, op, prt, dev, 2'b10, val};
      n = pre ? 32 : 64;
      exp = pre ? {32'h0, fr} : {32'hFFFF_FFFF, fr};
      mask = pre ? 64'hFFFF_FFFF : '1;
      if (kind != 2) wr(4'd13, {22'h0, prt, dev});
      ncap = 0;
      if (kind == 0) wr(4'd15, {16'h0, val});
      else if (kind == 1) wr(4'd14, {16'h0, val});
      else wr(4'd13, 32'h8000 | {22'h0, prt, dev});
      wait_idle(cyc);
      chk(cyc == 12 * n, "R7 busy duration", 64'(cyc), 64'(12 * n));
      chk(ncap == n, "R8 bit count", 64'(ncap), 64'(n));
      if (kind == 2) begin
        mask = mask & ~64'h3FFFF;
        chk(((cap_o ^ exp) & mask) == 0, "R5 read header", cap_o & mask, exp & mask);
        chk((cap_oe & (pre ? 64'hFFFF_FFFF : '1)) == (mask), "R5 oe release", cap_oe, mask);
        rd(4'd14, v); chk(v == {16'h0, val}, "R5 read data", v, {16'h0, val});
        rd(4'd12, v); chk(v[1] == bad, "R6 read error", v[1], bad);
      end else begin
        chk(((cap_o ^ exp) & mask) == 0, kind == 0 ? "R4 address frame" : "R3 write frame", cap_o & mask, exp & mask);
        chk((cap_oe & mask) == mask, "R3 oe driven", cap_oe & mask, mask);
        if (kind == 0) begin
          rd(4'd15, v); chk(v == {16'h0, val}, "R4 addr stored", v, {16'h0, val});
        end
      end
    end

    idle(16 * 12 + 20);
    rd(4'd14, v); chk(v == 32'hDEAD, "R11 data held", v, 32'hDEAD);

    wr(4'd12, 5 << 7);
    ncap = 0;
    wr(4'd15, 32'h5A5A);
    idle(50);
    rd(4'd12, v); chk(v[0] == 1'b0 && ncap == 0 && !mdc, "R4 direct addr no frame", {v[0], 32'(ncap)}, 0);
    rd(4'd15, v); chk(v == 32'h5A5A, "R4 direct addr stored", v, 32'h5A5A);

    wr(4'd12, 2 << 7);
    rd(4'd12, v); chk(v[15:7] == 9'd5, "R9 clamp 2", v[15:7], 5);
    wr(4'd12, 0);
    rd(4'd12, v); chk(v[15:7] == 9'd5, "R9 clamp 0", v[15:7], 5);

    cur_pre = 1'b1;
    wr(4'd12, (9 << 7) | 32'h20);
    wr(4'd13, 32'h22);
    ncap = 0;
    wr(4'd14, 32'h1111);
    wait_idle(cyc);
    chk(cyc == 640, "R7 divider 9 duration", 64'(cyc), 640);

    wr(4'd12, (5 << 7) | 32'h20);
    ncap = 0;
    wr(4'd14, 32'h7777);
    idle(40);
    wr(4'd14, 32'h2222);
    wr(4'd13, 32'h83E7);
    wr(4'd12, 32'h3F << 7);
    wait_idle(cyc);
    idle(40);
    chk(ncap == 32, "R10 single frame", 64'(ncap), 32);
    rd(4'd14, v); chk(v == 32'h7777, "R10 data kept", v, 32'h7777);
    rd(4'd13, v); chk(v == 32'h22, "R10 ctl kept", v, 32'h22);
    rd(4'd12, v); chk(v[15:7] == 9'd5, "R10 cfg kept", v[15:7], 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule